// File: doc/BRIEF.md
# 32-Source Interrupt Controller

This block collects up to 32 interrupt request lines, records each event in a pending-status register and drives two request outputs toward a processor: an ordinary one and a critical one. Every source is configured independently. One bit chooses edge or level detection, a second bit chooses which polarity counts as active, and a third bit sends the source to the critical output rather than the ordinary one. A per-source enable word gates the pending bits before they reach the outputs. The gated result can also be read back as its own register.

Software talks to the block through a flat word-wide register port made of an address, a write strobe, a read strobe and a data word. Pending bits are cleared by writing ones. A level-sensitive source whose input is still active cannot be cleared: its bit is set again straight away. The outputs are plain wires, so several controllers can be chained by feeding one block's output into an input of another.

Top module: `irq_hub`

## Requirements
- R1: After reset every register is zero. All sources are then disabled, level sensitive, active low and ordinary (not critical), and both outputs are low. Because the synchronizer also starts at zero, each source counts as active for the first cycles after reset and its pending bit becomes set.
- R2: Source n maps to bit (31 − n) of every per-source register. Source 0 is bit 31 and source 31 is bit 0.
- R3: A write to the pending-status word (offset 0x0) clears each bit where the data holds a 1 and leaves each bit where the data holds a 0. Writing 0xFFFFFFFF clears everything that has no new event.
- R4: A level-sensitive source whose input is active sets its pending bit on every cycle, whatever its enable bit says. Clearing the bit while the input stays active has no lasting effect. Once the input goes inactive, a clear sticks.
- R5: Detection mode is set per source in the trigger word (offset 0x5) and the polarity word (offset 0x4). Trigger 1 means edge and 0 means level. Polarity 1 means rising or high, and 0 means falling or low. With an edge setting, the opposite edge sets nothing.
- R6: The masked-status word (offset 0x6) reads as the pending bits AND the enable word (offset 0x2).
- R7: Pending bits are recorded while a source is disabled, and they do not appear in masked status. Setting the enable bit later exposes the held event.
- R8: A 1 in the critical-select word (offset 0x3) steers that source's masked bit to the critical output instead of the ordinary output.
- R9: When a new event and a clear of the same bit land in the same cycle, the bit stays set.
- R10: Each output is a register that takes the OR of the masked bits routed to it. An input change reaches the pending bit on the third rising clock edge and the output one edge later. A change to enable or routing reaches the output on the edge after the one that wrote it.
- R11: Writes to masked status and to unmapped offsets change nothing. Reads of unmapped offsets (0x1, 0x7 to 0xF) return zero, and the read data is zero while the read strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 32 | Interrupt inputs, index n is source n (asynchronous) |
| addr | input | 4 | Register word offset |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| rd_en | input | 1 | Read strobe, data is combinational |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data |
| irq_nc_o | output | 1 | Ordinary interrupt request |
| irq_crit_o | output | 1 | Critical interrupt request |

## Verification
A wrong pending bit shows up on the status read as soon as it happens. It reaches a request output one cycle later, but only if the source is enabled. A wrong sense or polarity setting shows up three edges after an input change, as a bit that is set or missing in status. A wrong routing or enable bit flips the wrong output exactly one edge after the write. A reversed bit order shows up at once as the wrong bit on every read. A lost set-over-clear priority shows up as a zero read straight after a clear that landed on an edge or on an active level.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;

  localparam int unsigned REG_AW = 4;

  localparam logic [REG_AW-1:0] OFS_STATUS = 4'h0;
  localparam logic [REG_AW-1:0] OFS_ENABLE = 4'h2;
  localparam logic [REG_AW-1:0] OFS_CRIT   = 4'h3;
  localparam logic [REG_AW-1:0] OFS_POL    = 4'h4;
  localparam logic [REG_AW-1:0] OFS_TRIG   = 4'h5;
  localparam logic [REG_AW-1:0] OFS_MASKED = 4'h6;

  // Event detector for one source: edge mode compares against last cycle,
  // level mode compares against the chosen active level.
  function automatic logic sense_hit(input logic trig, input logic pol,
                                     input logic cur, input logic last);
    logic rise;
    logic fall;
    rise = cur & ~last;
    fall = ~cur & last;
    if (trig) sense_hit = pol ? rise : fall;
    else      sense_hit = ~(cur ^ pol);
  endfunction

  // Register bit index holding a given source.
  function automatic int unsigned src_to_bit(input int unsigned src,
                                             input int unsigned width);
    src_to_bit = width - 1 - src;
  endfunction

endpackage

// File: rtl/irq_hub_sync.sv
module irq_hub_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/irq_hub_sense.sv
module irq_hub_sense
  import irq_hub_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cur,
  input  logic [W-1:0] trig,
  input  logic [W-1:0] pol,
  output logic [W-1:0] hit
);

  logic [W-1:0] last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= '0;
    else        last_q <= cur;
  end

  for (genvar b = 0; b < W; b++) begin : g_bit
    assign hit[b] = sense_hit(trig[b], pol[b], cur[b], last_q[b]);
  end

endmodule

// File: rtl/irq_hub_regs.sv
module irq_hub_regs
  import irq_hub_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [W-1:0]      wdata,
  input  logic [W-1:0]      set_evt,
  output logic [W-1:0]      rdata,
  output logic [W-1:0]      status,
  output logic [W-1:0]      masked,
  output logic [W-1:0]      crit_sel,
  output logic [W-1:0]      pol,
  output logic [W-1:0]      trig,
  output logic [W-1:0]      clr_vec
);

  logic [W-1:0] status_q;
  logic [W-1:0] enable_q;
  logic [W-1:0] crit_q;
  logic [W-1:0] pol_q;
  logic [W-1:0] trig_q;
  logic [W-1:0] rd_mux;

  logic wr_status;
  logic wr_enable;
  logic wr_crit;
  logic wr_pol;
  logic wr_trig;

  assign wr_status = wr_en && (addr == OFS_STATUS);
  assign wr_enable = wr_en && (addr == OFS_ENABLE);
  assign wr_crit   = wr_en && (addr == OFS_CRIT);
  assign wr_pol    = wr_en && (addr == OFS_POL);
  assign wr_trig   = wr_en && (addr == OFS_TRIG);

  assign clr_vec = wr_status ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      enable_q <= '0;
      crit_q   <= '0;
      pol_q    <= '0;
      trig_q   <= '0;
    end else begin
      // a fresh event outranks a clear of the same bit
      status_q <= (status_q & ~clr_vec) | set_evt;
      if (wr_enable) enable_q <= wdata;
      if (wr_crit)   crit_q   <= wdata;
      if (wr_pol)    pol_q    <= wdata;
      if (wr_trig)   trig_q   <= wdata;
    end
  end

  assign status   = status_q;
  assign masked   = status_q & enable_q;
  assign crit_sel = crit_q;
  assign pol      = pol_q;
  assign trig     = trig_q;

  always_comb begin
    case (addr)
      OFS_STATUS: rd_mux = status_q;
      OFS_ENABLE: rd_mux = enable_q;
      OFS_CRIT:   rd_mux = crit_q;
      OFS_POL:    rd_mux = pol_q;
      OFS_TRIG:   rd_mux = trig_q;
      OFS_MASKED: rd_mux = masked;
      default:    rd_mux = '0;
    endcase
  end

  assign rdata = rd_en ? rd_mux : '0;

endmodule

// File: rtl/irq_hub_route.sv
module irq_hub_route #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] masked,
  input  logic [W-1:0] crit_sel,
  output logic         irq_nc_o,
  output logic         irq_crit_o
);

  logic nc_any;
  logic crit_any;

  assign nc_any   = |(masked & ~crit_sel);
  assign crit_any = |(masked & crit_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_nc_o   <= 1'b0;
      irq_crit_o <= 1'b0;
    end else begin
      irq_nc_o   <= nc_any;
      irq_crit_o <= crit_any;
    end
  end

endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irq_hub_pkg::*;
#(
  parameter int unsigned NSRC        = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   irq_in,
  input  logic [REG_AW-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [NSRC-1:0]   wdata,
  output logic [NSRC-1:0]   rdata,
  output logic              irq_nc_o,
  output logic              irq_crit_o
);

  logic [NSRC-1:0] irq_bits;
  logic [NSRC-1:0] irq_sync;
  logic [NSRC-1:0] set_evt;
  logic [NSRC-1:0] status;
  logic [NSRC-1:0] masked;
  logic [NSRC-1:0] crit_sel;
  logic [NSRC-1:0] pol;
  logic [NSRC-1:0] trig;
  logic [NSRC-1:0] clr_vec;

  // source n lives in register bit NSRC-1-n
  for (genvar n = 0; n < NSRC; n++) begin : g_rev
    assign irq_bits[src_to_bit(n, NSRC)] = irq_in[n];
  end

  irq_hub_sync #(.W(NSRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (irq_bits),
    .q     (irq_sync)
  );

  irq_hub_sense #(.W(NSRC)) u_sense (
    .clk   (clk),
    .rst_n (rst_n),
    .cur   (irq_sync),
    .trig  (trig),
    .pol   (pol),
    .hit   (set_evt)
  );

  irq_hub_regs #(.W(NSRC)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (addr),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .wdata    (wdata),
    .set_evt  (set_evt),
    .rdata    (rdata),
    .status   (status),
    .masked   (masked),
    .crit_sel (crit_sel),
    .pol      (pol),
    .trig     (trig),
    .clr_vec  (clr_vec)
  );

  irq_hub_route #(.W(NSRC)) u_route (
    .clk        (clk),
    .rst_n      (rst_n),
    .masked     (masked),
    .crit_sel   (crit_sel),
    .irq_nc_o   (irq_nc_o),
    .irq_crit_o (irq_crit_o)
  );

endmodule

// File: rtl/irq_hub_chk.sv
module irq_hub_chk #(
  parameter int unsigned W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] status,
  input logic [W-1:0] set_evt,
  input logic [W-1:0] clr_vec,
  input logic [W-1:0] masked,
  input logic [W-1:0] crit_sel,
  input logic         irq_nc_o,
  input logic         irq_crit_o
);

  a_r10_nc_follows: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_nc_o == (|$past(masked & ~crit_sel))));

  a_r8_crit_follows: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_crit_o == (|$past(masked & crit_sel))));

  a_r3_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & $past(clr_vec & ~set_evt)) == '0));

  a_r3_hold_unwritten: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(status & ~clr_vec) & ~status) == '0));

  a_r9_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & $past(set_evt)) == $past(set_evt)));

endmodule

bind irq_hub irq_hub_chk #(.W(NSRC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .status     (status),
  .set_evt    (set_evt),
  .clr_vec    (clr_vec),
  .masked     (masked),
  .crit_sel   (crit_sel),
  .irq_nc_o   (irq_nc_o),
  .irq_crit_o (irq_crit_o)
);

// File: tb/sim_irq_hub.sv
`timescale 1ns/1ps
module sim_irq_hub;

  localparam int NS = 32;
  localparam int MAXCYC = 200000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] irq_in = '1;
  logic [3:0]    addr = '0;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [NS-1:0] wdata = '0;
  logic [NS-1:0] rdata;
  logic          irq_nc_o;
  logic          irq_crit_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_hub u0 (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .addr(addr), .wr_en(wr_en),
    .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .irq_nc_o(irq_nc_o),
    .irq_crit_o(irq_crit_o)
  );

  // behavioural reference, indexed by source number
  bit m_s1 [NS];
  bit m_s2 [NS];
  bit m_pv [NS];
  bit m_st [NS];
  bit m_en [NS];
  bit m_cs [NS];
  bit m_po [NS];
  bit m_tr [NS];
  bit m_nc, m_co;

  always @(posedge clk or negedge rst_n) begin
    bit nc, co, clr;
    bit hit [NS];
    if (!rst_n) begin
      for (int n = 0; n < NS; n++) begin
        m_s1[n] = 0; m_s2[n] = 0; m_pv[n] = 0; m_st[n] = 0;
        m_en[n] = 0; m_cs[n] = 0; m_po[n] = 0; m_tr[n] = 0;
      end
      m_nc = 0; m_co = 0;
    end else begin
      nc = 0; co = 0;
      for (int n = 0; n < NS; n++) begin
        if (m_st[n] && m_en[n]) begin
          if (m_cs[n]) co = 1; else nc = 1;
        end
        if (m_tr[n]) hit[n] = m_po[n] ? (m_s2[n] && !m_pv[n]) : (!m_s2[n] && m_pv[n]);
        else         hit[n] = (m_s2[n] == m_po[n]);
      end
      for (int n = 0; n < NS; n++) begin
        clr = wr_en && (addr == 4'h0) && wdata[NS-1-n];
        if (wr_en) begin
          case (addr)
            4'h2: m_en[n] = wdata[NS-1-n];
            4'h3: m_cs[n] = wdata[NS-1-n];
            4'h4: m_po[n] = wdata[NS-1-n];
            4'h5: m_tr[n] = wdata[NS-1-n];
            default: ;
          endcase
        end
        m_st[n] = (m_st[n] && !clr) || hit[n];
        m_pv[n] = m_s2[n];
        m_s2[n] = m_s1[n];
        m_s1[n] = irq_in[n];
      end
      m_nc = nc; m_co = co;
    end
  end

  function automatic logic [NS-1:0] model_word(input logic [3:0] a);
    logic [NS-1:0] w;
    w = '0;
    for (int n = 0; n < NS; n++) begin
      case (a)
        4'h0: w[NS-1-n] = m_st[n];
        4'h2: w[NS-1-n] = m_en[n];
        4'h3: w[NS-1-n] = m_cs[n];
        4'h4: w[NS-1-n] = m_po[n];
        4'h5: w[NS-1-n] = m_tr[n];
        4'h6: w[NS-1-n] = m_st[n] & m_en[n];
        default: ;
      endcase
    end
    return w;
  endfunction

  task automatic chk(input string tag, input logic [NS-1:0] act, input logic [NS-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // outputs against the reference on every clock
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R10 ordinary output vs model", {31'b0, irq_nc_o}, {31'b0, m_nc});
      chk("R8 critical output vs model", {31'b0, irq_crit_o}, {31'b0, m_co});
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [NS-1:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [NS-1:0] exp, input string tag);
    addr = a; rd_en = 1'b1;
    #1;
    chk(tag, rdata, exp);
    chk({tag, " (model)"}, rdata, model_word(a));
    rd_en = 1'b0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(8.0 * MAXCYC);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    tick(3);
    // R1: reset contents and outputs
    rd(4'h0, '0, "R1 status at reset");
    rd(4'h2, '0, "R1 enable at reset");
    rd(4'h3, '0, "R1 critical select at reset");
    rd(4'h4, '0, "R1 polarity at reset");
    rd(4'h5, '0, "R1 trigger at reset");
    rd(4'h6, '0, "R1 masked at reset");
    chk("R1 outputs at reset", {30'b0, irq_nc_o, irq_crit_o}, '0);
    rst_n = 1'b1;
    tick(5);
    rd(4'h0, 32'hFFFF_FFFF, "R1 default level-low latches zeroed sync");
    chk("R1 outputs stay low while disabled", {30'b0, irq_nc_o, irq_crit_o}, '0);

    // all sources rising edge, then clear everything
    wr(4'h5, 32'hFFFF_FFFF);
    wr(4'h4, 32'hFFFF_FFFF);
    wr(4'h0, 32'hFFFF_FFFF);
    rd(4'h0, '0, "R3 write all ones clears");

    // source 3 pulse -> bit 28
    irq_in[3] = 1'b0; tick(4);
    irq_in[3] = 1'b1; tick(4);
    rd(4'h0, 32'h1000_0000, "R2 source 3 is bit 28 / R5 rising only");
    rd(4'h6, '0, "R7 disabled source hidden in masked");
    chk("R7 disabled source drives nothing", {31'b0, irq_nc_o}, '0);
    wr(4'h2, 32'h1000_0000);
    rd(4'h6, 32'h1000_0000, "R6 R7 enable exposes held event");
    chk("R10 output one edge after enable", {31'b0, irq_nc_o}, '0);
    tick(1);
    chk("R10 ordinary output rises", {31'b0, irq_nc_o}, 32'h1);
    wr(4'h3, 32'h1000_0000);
    tick(1);
    chk("R8 routed to critical", {30'b0, irq_nc_o, irq_crit_o}, 32'h1);
    wr(4'h0, '0);
    rd(4'h0, 32'h1000_0000, "R3 zero write keeps bit");
    wr(4'h0, 32'h1000_0000);
    rd(4'h0, '0, "R3 one write clears bit");
    tick(1);
    chk("R3 critical output drops after clear", {31'b0, irq_crit_o}, '0);

    // source 5 falling edge -> bit 26
    wr(4'h4, 32'hFBFF_FFFF);
    irq_in[5] = 1'b0; tick(4);
    rd(4'h0, 32'h0400_0000, "R5 falling edge sets");
    wr(4'h0, 32'h0400_0000);
    irq_in[5] = 1'b1; tick(4);
    rd(4'h0, '0, "R5 rising edge ignored in falling mode");

    // source 7 level high -> bit 24
    wr(4'h5, 32'hFEFF_FFFF);
    tick(2);
    rd(4'h0, 32'h0100_0000, "R4 active level sets while disabled");
    wr(4'h0, 32'h0100_0000);
    rd(4'h0, 32'h0100_0000, "R4 clear undone while level active");
    irq_in[7] = 1'b0; tick(4);
    wr(4'h0, 32'h0100_0000);
    rd(4'h0, '0, "R4 clear sticks once inactive");

    // source 10 rising edge coincides with clear -> bit 21
    irq_in[10] = 1'b0; tick(4);
    rd(4'h0, '0, "R5 falling ignored in rising mode");
    irq_in[10] = 1'b1; tick(2);
    wr(4'h0, 32'h0020_0000);
    rd(4'h0, 32'h0020_0000, "R9 edge wins over same-cycle clear");
    wr(4'h0, 32'h0020_0000);
    rd(4'h0, '0, "R9 later clear works");

    // sources 0 and 31 -> bits 31 and 0
    irq_in[0] = 1'b0; irq_in[31] = 1'b0; tick(4);
    irq_in[0] = 1'b1; irq_in[31] = 1'b1; tick(4);
    rd(4'h0, 32'h8000_0001, "R2 source 0 is MSB, source 31 is LSB");
    wr(4'h0, 32'hFFFF_FFFF);

    // read-only and unmapped
    wr(4'h6, 32'hFFFF_FFFF);
    wr(4'h1, 32'hFFFF_FFFF);
    wr(4'h9, 32'hFFFF_FFFF);
    rd(4'h0, '0, "R11 masked write leaves status");
    rd(4'h2, 32'h1000_0000, "R11 enable untouched");
    rd(4'h3, 32'h1000_0000, "R11 critical select untouched");
    rd(4'h4, 32'hFBFF_FFFF, "R11 polarity untouched");
    rd(4'h5, 32'hFEFF_FFFF, "R11 trigger untouched");
    rd(4'h1, '0, "R11 offset 1 reads zero");
    rd(4'h7, '0, "R11 offset 7 reads zero");
    rd(4'hF, '0, "R11 offset 15 reads zero");
    addr = 4'h2; rd_en = 1'b0; #1;
    chk("R11 read data zero without strobe", rdata, '0);

    // mixed traffic against the model
    for (int c = 0; c < 4000; c++) begin
      wr_en = (($urandom % 6) == 0);
      addr  = 4'($urandom % 8);
      wdata = (($urandom % 3) == 0) ? 32'hFFFF_FFFF : $urandom;
      if (($urandom % 3) == 0) irq_in[$urandom % NS] ^= 1'b1;
      rd_en = 1'b1;
      #1;
      chk("R6 R10 read vs model", rdata, model_word(addr));
      @(negedge clk);
    end
    wr_en = 1'b0; rd_en = 1'b0;
    tick(2);
    done = 1;
    summary();
    $finish;
  end

endmodule